// File: doc/BRIEF.md
# Noise Power Histogram Engine

The block measures the noise floor of a receiver over a programmable window. One power value arrives with each sample tick, one tick every 4 microseconds. The block compares that value against eleven programmable thresholds and adds it to one of twelve histogram bins. Software writes the thresholds, the window length and a control word through a small register-style write port. A rising edge of the trigger bit starts a measurement, and a sticky ready flag shows when the window has closed. The bin counts and the count of accepted ticks are then read back.

Samples can be left out while carrier sense reports the medium busy, or while the local transmitter is on. Each of these two masks has its own control bit. Power is an unsigned value in half-dB steps, so a code c stands for c/2 - 110 dBm. The thresholds use the same scale.

Top module: `nhist_engine`

## Requirements
- R1: The bin index of an accepted sample is the lowest k (0..10) for which the power is less than threshold k (unsigned 8-bit compare). If no such k exists, the index is 11. With non-decreasing thresholds, bin 0 takes power below threshold 0, bin k takes threshold k-1 <= power < threshold k, and bin 11 takes power at or above threshold 10. Threshold k is written at address 2+k, in data bits [7:0].
- R2: The window length N, in ticks, is held at address 1, data bits [15:0], and resets to 0xC350. After a start, only the first N ticks can be counted. Ready rises at the clock edge that takes the N-th tick. With N = 0, the first tick ends the window and nothing is counted.
- R3: A bin counter stops at 255 and does not wrap.
- R4: The control word is at address 0: bit 0 is the enable, bit 1 the trigger, bit 2 keeps carrier-busy samples, bit 3 keeps transmit-on samples. A start happens only when a control write sets bit 1 while the stored trigger bit is 0. Writing 1 again over a stored 1 changes nothing.
- R5: A control write whose bit 0 is 0 never starts a measurement. The counts, the duration and ready keep their values.
- R6: Ready is 0 from a start until its window ends. It then stays 1 until the next start. Ready and busy are never 1 together.
- R7: While control bit 2 is 0, a tick with carrierBusy high adds to no bin and not to the duration.
- R8: While control bit 3 is 0, a tick with txOn high adds to no bin and not to the duration.
- R9: The duration counts the window ticks whose sample was accepted, meaning it was not masked.
- R10: Every start clears all bins and the duration. A start during an open window abandons that window and begins a new one of N ticks.
- R11: After reset, all bins, the duration, ready and busy are 0, and all thresholds are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAddr | input | 4 | Configuration address |
| cfgWdata | input | 16 | Configuration write data |
| tick | input | 1 | Sample strobe, one per 4 us |
| power | input | 8 | Sample power, half-dB code |
| carrierBusy | input | 1 | Carrier sense busy |
| txOn | input | 1 | Transmitter active |
| rdSel | input | 4 | Bin selected for readout |
| rdCount | output | 8 | Count of the selected bin (0 if rdSel > 11) |
| duration | output | 16 | Accepted tick count |
| ready | output | 1 | Window complete, sticky |
| busy | output | 1 | Window open |

## Verification
The assertions assume that tick is a single-cycle strobe. They also assume that nothing changes cfgWe, cfgAddr or cfgWdata while a start is being decided. They further assume that the window is never longer than the 16-bit duration can hold, so the duration never wraps. The stimulus drives each input only at the falling edge and raises tick for exactly one cycle. Configuration writes and ticks never fall in the same cycle. The random part draws power, the two mask inputs and the two mask control bits freely, over windows no longer than a few hundred ticks.

// File: rtl/nhist_pkg.sv
package nhist_pkg;
  localparam int ADDR_CTRL    = 0;
  localparam int ADDR_WINDOW  = 1;
  localparam int ADDR_TH_BASE = 2;

  localparam int CTRL_ENABLE  = 0;
  localparam int CTRL_TRIGGER = 1;
  localparam int CTRL_KEEP_CB = 2;
  localparam int CTRL_KEEP_TX = 3;

  typedef struct packed {
    logic clearAll;
    logic sampleEn;
  } nhStrobe_t;
endpackage

// File: rtl/nhist_ctrl.sv
module nhist_ctrl
  import nhist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int WIN_W  = 16,
  parameter logic [WIN_W-1:0] WIN_RESET = 16'hC350
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              tick,
  input  logic              carrierBusy,
  input  logic              txOn,
  output nhStrobe_t         strb,
  output logic              ready,
  output logic              busy
);
  logic             enableReg, trigReg, keepCb, keepTx;
  logic [WIN_W-1:0] winLen, remaining;
  logic             ctrlWrite, startNow, lastTick, accepted;

  assign ctrlWrite = cfgWe && (cfgAddr == ADDR_W'(ADDR_CTRL));
  assign startNow  = ctrlWrite && cfgWdata[CTRL_TRIGGER] && !trigReg
                     && cfgWdata[CTRL_ENABLE];
  assign lastTick  = (remaining <= WIN_W'(1));
  assign accepted  = (keepCb || !carrierBusy) && (keepTx || !txOn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enableReg <= 1'b0;
      trigReg   <= 1'b0;
      keepCb    <= 1'b0;
      keepTx    <= 1'b0;
      winLen    <= WIN_RESET;
    end else if (cfgWe) begin
      if (cfgAddr == ADDR_W'(ADDR_CTRL)) begin
        enableReg <= cfgWdata[CTRL_ENABLE];
        trigReg   <= cfgWdata[CTRL_TRIGGER];
        keepCb    <= cfgWdata[CTRL_KEEP_CB];
        keepTx    <= cfgWdata[CTRL_KEEP_TX];
      end else if (cfgAddr == ADDR_W'(ADDR_WINDOW)) begin
        winLen <= cfgWdata[WIN_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      ready     <= 1'b0;
      remaining <= '0;
    end else if (startNow) begin
      busy      <= 1'b1;
      ready     <= 1'b0;
      remaining <= winLen;
    end else if (busy && tick) begin
      if (lastTick) begin
        busy      <= 1'b0;
        ready     <= 1'b1;
        remaining <= '0;
      end else begin
        remaining <= remaining - WIN_W'(1);
      end
    end
  end

  always_comb begin
    strb.clearAll = startNow;
    strb.sampleEn = busy && tick && !startNow && (remaining != '0) && accepted;
  end

  always @(posedge clk) begin
    if (rstN) begin
      p_ready_excl_r6: assert (!(ready && busy))
        else $error("ready and busy both set");
    end
  end

  p_ready_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !strb.clearAll) |=> ready);

  p_start_opens_r10: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (busy && !ready));

  p_idle_no_sample_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !strb.sampleEn);

  p_gate_enable_r5: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWrite && !cfgWdata[CTRL_ENABLE] && !busy) |=> !busy);

  p_remaining_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !tick && !strb.clearAll) |=> $stable(remaining));
endmodule

// File: rtl/nhist_datapath.sv
module nhist_datapath
  import nhist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int PWR_W  = 8,
  parameter int CNT_W  = 8,
  parameter int DUR_W  = 16,
  parameter int NUM_TH = 11,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic [PWR_W-1:0]  power,
  input  nhStrobe_t         strb,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CNT_W-1:0]  rdCount,
  output logic [DUR_W-1:0]  duration
);
  localparam int NUM_BINS = NUM_TH + 1;
  localparam int IDX_W    = $clog2(NUM_BINS);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [PWR_W-1:0] thReg  [NUM_TH];
  logic [CNT_W-1:0] binCnt [NUM_BINS];
  logic [IDX_W-1:0] binIdx;

  for (genvar t = 0; t < NUM_TH; t++) begin : g_th
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) thReg[t] <= '0;
      else if (cfgWe && cfgAddr == ADDR_W'(ADDR_TH_BASE + t))
        thReg[t] <= cfgWdata[PWR_W-1:0];
    end
  end

  always_comb begin
    binIdx = IDX_W'(NUM_TH);
    for (int k = NUM_TH - 1; k >= 0; k--) begin
      if (power < thReg[k]) binIdx = IDX_W'(k);
    end
  end

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) binCnt[b] <= '0;
      else if (strb.clearAll) binCnt[b] <= '0;
      else if (strb.sampleEn && binIdx == IDX_W'(b) && binCnt[b] != CNT_MAX)
        binCnt[b] <= binCnt[b] + CNT_W'(1);
    end

    p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
      (binCnt[b] == CNT_MAX && !strb.clearAll) |=> binCnt[b] == CNT_MAX);

    p_no_drop_r1: assert property (@(posedge clk) disable iff (!rstN)
      !strb.clearAll |=> binCnt[b] >= $past(binCnt[b]));

    p_clear_bin_r10: assert property (@(posedge clk) disable iff (!rstN)
      strb.clearAll |=> binCnt[b] == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) duration <= '0;
    else if (strb.clearAll) duration <= '0;
    else if (strb.sampleEn) duration <= duration + DUR_W'(1);
  end

  always_comb begin
    rdCount = '0;
    if (rdSel < SEL_W'(NUM_BINS)) rdCount = binCnt[rdSel];
  end

  p_dur_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (strb.sampleEn && !strb.clearAll) |=> duration == $past(duration) + DUR_W'(1));

  p_dur_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.sampleEn && !strb.clearAll) |=> $stable(duration));
endmodule

// File: rtl/nhist_engine.sv
module nhist_engine
  import nhist_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int PWR_W  = 8,
  parameter int CNT_W  = 8,
  parameter int WIN_W  = 16,
  parameter int NUM_TH = 11,
  parameter int SEL_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgWdata,
  input  logic              tick,
  input  logic [PWR_W-1:0]  power,
  input  logic              carrierBusy,
  input  logic              txOn,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [CNT_W-1:0]  rdCount,
  output logic [WIN_W-1:0]  duration,
  output logic              ready,
  output logic              busy
);
  nhStrobe_t strb;

  nhist_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIN_W(WIN_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .tick(tick), .carrierBusy(carrierBusy),
    .txOn(txOn), .strb(strb), .ready(ready), .busy(busy)
  );

  nhist_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PWR_W(PWR_W), .CNT_W(CNT_W),
    .DUR_W(WIN_W), .NUM_TH(NUM_TH), .SEL_W(SEL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .power(power), .strb(strb), .rdSel(rdSel),
    .rdCount(rdCount), .duration(duration)
  );
endmodule

// File: tb/nhist_engine_test.sv
module nhist_engine_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgWdata = '0;
  logic        tick = 1'b0;
  logic [7:0]  power = '0;
  logic        carrierBusy = 1'b0;
  logic        txOn = 1'b0;
  logic [3:0]  rdSel = '0;
  logic [7:0]  rdCount;
  logic [15:0] duration;
  logic        ready, busy;

  nhist_engine uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgWdata(cfgWdata), .tick(tick), .power(power),
    .carrierBusy(carrierBusy), .txOn(txOn), .rdSel(rdSel),
    .rdCount(rdCount), .duration(duration), .ready(ready), .busy(busy)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  logic [7:0]  mTh [11];
  int          mCnt [12];
  int          mDur;
  logic [15:0] mWin;
  int          mRem;
  bit          mBusy, mReady, mTrig, mKeepCb, mKeepTx;

  function automatic int expBin(logic [7:0] p);
    for (int k = 0; k < 11; k++) if (p < mTh[k]) return k;
    return 11;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic writeReg(logic [3:0] a, logic [15:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = a; cfgWdata = d;
    @(negedge clk);
    cfgWe = 1'b0;
    if (a == 4'd0) begin
      if (d[1] && !mTrig && d[0]) begin
        for (int b = 0; b < 12; b++) mCnt[b] = 0;
        mDur = 0; mRem = mWin; mBusy = 1; mReady = 0;
      end
      mTrig = d[1]; mKeepCb = d[2]; mKeepTx = d[3];
    end else if (a == 4'd1) mWin = d;
    else if (a >= 4'd2 && a <= 4'd12) mTh[a - 2] = d[7:0];
  endtask

  task automatic sample(logic [7:0] p, bit cb, bit tx);
    @(negedge clk);
    tick = 1'b1; power = p; carrierBusy = cb; txOn = tx;
    @(negedge clk);
    tick = 1'b0;
    if (mBusy) begin
      if (mRem != 0 && (mKeepCb || !cb) && (mKeepTx || !tx)) begin
        int bi = expBin(p);
        if (mCnt[bi] < 255) mCnt[bi]++;
        mDur++;
      end
      if (mRem <= 1) begin mBusy = 0; mReady = 1; mRem = 0; end
      else mRem--;
    end
  endtask

  task automatic checkAll(string tag);
    for (int b = 0; b < 12; b++) begin
      @(negedge clk);
      rdSel = 4'(b);
      #1;
      check(tag, $sformatf("bin%0d", b), int'(rdCount), mCnt[b]);
    end
    check(tag, "duration", int'(duration), mDur);
    check(tag, "ready", int'(ready), int'(mReady));
    check(tag, "busy", int'(busy), int'(mBusy));
  endtask

  task automatic arm(logic [15:0] ctrlBits);
    writeReg(4'd0, ctrlBits & 16'hFFFD);
    writeReg(4'd0, ctrlBits | 16'h0002);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7315));
    for (int k = 0; k < 11; k++) mTh[k] = 8'd0;
    for (int b = 0; b < 12; b++) mCnt[b] = 0;
    mDur = 0; mWin = 16'hC350; mRem = 0;
    mBusy = 0; mReady = 0; mTrig = 0; mKeepCb = 0; mKeepTx = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R11 reset state
    checkAll("R11");

    // R1 boundaries: thresholds 0x40 + 8k
    for (int k = 0; k < 11; k++) writeReg(4'(2 + k), 16'(8'h40 + 8 * k));
    writeReg(4'd1, 16'd20);
    arm(16'h000D);
    sample(8'h3F, 0, 0); sample(8'h40, 0, 0); sample(8'h47, 0, 0);
    sample(8'h48, 0, 0); sample(8'h8F, 0, 0); sample(8'h90, 0, 0);
    sample(8'hFF, 0, 0); sample(8'h00, 0, 0);
    checkAll("R1");

    // R4 rewriting trigger=1 over stored 1 does not restart
    writeReg(4'd0, 16'h000F);
    sample(8'h55, 0, 0);
    checkAll("R4");

    // R2 finish the window and see ready; R6 ready sticky
    while (mBusy) sample(8'h60, 0, 0);
    checkAll("R2");
    sample(8'h60, 0, 0);
    repeat (3) @(negedge clk);
    checkAll("R6");

    // R5 enable low: trigger edge ignored
    writeReg(4'd0, 16'h0000);
    writeReg(4'd0, 16'h0002);
    sample(8'h20, 0, 0);
    checkAll("R5");

    // R7 carrier-busy mask
    writeReg(4'd1, 16'd30);
    arm(16'h0009);
    sample(8'h10, 1, 0); sample(8'h10, 0, 0); sample(8'h80, 1, 1);
    checkAll("R7");

    // R8 transmit mask
    arm(16'h0005);
    sample(8'h10, 0, 1); sample(8'h10, 1, 0); sample(8'h99, 0, 0);
    checkAll("R8");

    // R10 retrigger mid-window clears and restarts
    sample(8'h44, 0, 0);
    arm(16'h000D);
    sample(8'h44, 0, 0);
    checkAll("R10");

    // R2 zero-length window
    writeReg(4'd1, 16'd0);
    arm(16'h000D);
    sample(8'h44, 0, 0);
    checkAll("R2");

    // R3 saturation
    writeReg(4'd1, 16'd300);
    arm(16'h000D);
    for (int i = 0; i < 290; i++) sample(8'h41, 0, 0);
    checkAll("R3");

    // R1 non-monotonic thresholds
    writeReg(4'd2, 16'h0080);
    writeReg(4'd3, 16'h0030);
    writeReg(4'd1, 16'd10);
    arm(16'h000D);
    sample(8'h50, 0, 0); sample(8'h20, 0, 0); sample(8'h80, 0, 0);
    checkAll("R1");

    // R9 random windows with random masks and inputs
    for (int w = 0; w < 6; w++) begin
      for (int k = 0; k < 11; k++) writeReg(4'(2 + k), 16'($urandom_range(255)));
      writeReg(4'd1, 16'($urandom_range(40, 200)));
      arm(16'h0001 | 16'($urandom_range(3) << 2));
      for (int i = 0; i < 220; i++)
        sample(8'($urandom_range(255)), bit'($urandom_range(1)), bit'($urandom_range(1)));
      checkAll("R9");
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule